// File: doc/BRIEF.md
# ROM Patch Address Matcher

This block repairs up to four instructions in a fixed program ROM. It watches every instruction fetch address. When the address equals one of four programmed patch locations whose channel is enabled, it asks the core to replace the fetched opcode with a table-call instruction. It also reports which channel matched, so that the core can pick the call-table entry that holds the replacement code.

Software sets the block up through a small register port. A control register holds a two-bit channel selector and four per-channel enable flags. An address is loaded in two steps. The upper byte is first placed in a staging register. Writing the lower 16 bits then copies the combined address into the pointer of the currently selected channel. The block registers its output, so the call request appears one cycle after a valid fetch.

Top module: `rom_patch_matcher`

## Requirements
- R1: After reset, the control register reads 0x00, the staging byte reads 0, every channel pointer reads 0 and `patch_req` is low.
- R2: A full write (`bus_mode`=0) to register 0 loads control bits [1:0] (channel select) and [7:4] (enables). Bits [3:2] and [15:8] always read back as zero.
- R3: `bus_mode`=1 sets and `bus_mode`=2 clears the single control bit indexed by `bus_wdata[2:0]`. Every other control bit keeps its value. A set or clear aimed at bit 2 or bit 3 has no effect. `bus_mode`=3 and bit operations on registers 1 to 3 change nothing.
- R4: A full write to register 2 loads the pointer of the channel selected by control bits [1:0] with {staging byte, `bus_wdata`}, and no other pointer changes. Register 2 reads the low 16 bits of the selected pointer, and register 3 reads its high byte.
- R5: A full write to register 1 changes only the staging byte, which register 1 reads back. No pointer changes until register 2 is written. Writes to register 3 are ignored.
- R6: Channel n is enabled by control bit 4+n. A disabled channel never produces a request, whatever address it holds.
- R7: When `fetch_valid` is high and `fetch_addr` equals the pointer of an enabled channel, `patch_req` is high in the next cycle only, with that channel on `patch_ch`. Each valid fetch yields its own one-cycle result. While `patch_req` is low, `patch_ch` is 0.
- R8: If several enabled channels match the same fetch, the lowest-numbered channel is reported.
- R9: A fetch with `fetch_valid` low never produces a request. Comparison uses the register state from before any bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_mode | input | 2 | Write kind: 0 full, 1 bit set, 2 bit clear, 3 none |
| bus_addr | input | 2 | Register index: 0 control, 1 staging high byte, 2 low address / pointer low, 3 pointer high (read only) |
| bus_wdata | input | 16 | Write data; bits [2:0] give the bit index for set/clear |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_addr | input | 24 | Instruction fetch address |
| patch_req | output | 1 | Request to inject a table call, one cycle after the fetch |
| patch_ch | output | 2 | Index of the matching channel |

## Verification
The bench builds the block with its default 24-bit address and 16-bit low half. With these values the staging byte carries the only bits that the low write lacks. The bench therefore loads each channel with a distinct upper byte, which shows whether the pointer is built as {staging byte, low data}. A behavioural model recomputes the expected request and channel on every clock. This covers duplicate addresses across channels, back-to-back fetches, a fetch in the same cycle as a control write, and a disabled channel that holds the reset address 0.

// File: rtl/rom_patch_matcher.sv
module rom_patch_matcher #(
  parameter int ADDR_W = 24,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_mode,
  input  logic [1:0]        bus_addr,
  input  logic [LO_W-1:0]   bus_wdata,
  output logic [LO_W-1:0]   bus_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              patch_req,
  output logic [1:0]        patch_ch
);
  // Channel count is fixed by the control layout: 2-bit select, 4 enables.
  localparam int NUM_CH = 4;
  localparam int HI_W   = ADDR_W - LO_W;

  logic [1:0]                     sel_q;
  logic [NUM_CH-1:0]              en_q;
  logic [HI_W-1:0]                hi_q;
  logic [NUM_CH-1:0][ADDR_W-1:0]  ptr_q;

  logic [7:0]        ctrl_rd;
  logic [7:0]        ctrl_nx;
  logic [7:0]        bit_mask;
  logic [NUM_CH-1:0] hit;
  logic              any_hit;
  logic [1:0]        hit_ch;

  assign ctrl_rd  = {en_q, 2'b00, sel_q};
  assign bit_mask = 8'(1) << bus_wdata[2:0];

  always_comb begin
    ctrl_nx = ctrl_rd;
    if (bus_mode == 2'd0)      ctrl_nx = bus_wdata[7:0];
    else if (bus_mode == 2'd1) ctrl_nx = ctrl_rd | bit_mask;
    else if (bus_mode == 2'd2) ctrl_nx = ctrl_rd & ~bit_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
      hi_q  <= '0;
      ptr_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == 2'd0) begin
        sel_q <= ctrl_nx[1:0];
        en_q  <= ctrl_nx[7:4];
      end
      if (bus_addr == 2'd1 && bus_mode == 2'd0)
        hi_q <= bus_wdata[HI_W-1:0];
      if (bus_addr == 2'd2 && bus_mode == 2'd0)
        ptr_q[sel_q] <= {hi_q, bus_wdata};
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{(LO_W-8){1'b0}}, ctrl_rd};
      2'd1:    bus_rdata = {{(LO_W-HI_W){1'b0}}, hi_q};
      2'd2:    bus_rdata = ptr_q[sel_q][LO_W-1:0];
      default: bus_rdata = {{(LO_W-HI_W){1'b0}}, ptr_q[sel_q][ADDR_W-1:LO_W]};
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cmp
      assign hit[g] = en_q[g] && (ptr_q[g] == fetch_addr);
    end
  endgenerate

  assign any_hit = fetch_valid && (|hit);

  always_comb begin
    hit_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (hit[i]) hit_ch = 2'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      patch_req <= 1'b0;
      patch_ch  <= '0;
    end else begin
      patch_req <= any_hit;
      patch_ch  <= any_hit ? hit_ch : 2'd0;
    end
  end

  p_req_needs_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    patch_req |-> $past(fetch_valid));

  p_idle_ch_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_req |-> patch_ch == 2'd0);

  p_enabled_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    patch_req |-> |($past(en_q) & (4'b0001 << patch_ch)));

  p_stage_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> $stable(ptr_q));

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> bus_rdata[3:2] == 2'b00);
endmodule

// File: tb/rom_patch_matcher_tb_top.sv
module rom_patch_matcher_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_mode = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        fetch_valid = 0;
  logic [23:0] fetch_addr = 0;
  logic        patch_req;
  logic [1:0]  patch_ch;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  rom_patch_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_mode(bus_mode),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .patch_req(patch_req), .patch_ch(patch_ch));

  // behavioural reference
  int m_sel, m_en, m_hi;
  int m_ptr [4];
  bit m_req;
  int m_ch;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_en = 0; m_hi = 0; m_req = 0; m_ch = 0;
      foreach (m_ptr[k]) m_ptr[k] = 0;
    end else begin
      int c, idx, found;
      found = -1;
      if (fetch_valid)
        for (int k = 3; k >= 0; k--)
          if (((m_en >> k) & 1) == 1 && m_ptr[k] == int'(fetch_addr)) found = k;
      m_req = (found >= 0);
      m_ch  = m_req ? found : 0;
      if (bus_wr) begin
        c = (m_en << 4) | m_sel;
        idx = int'(bus_wdata[2:0]);
        if (bus_addr == 0) begin
          if (bus_mode == 0) c = int'(bus_wdata[7:0]);
          else if (bus_mode == 1) c = c | (1 << idx);
          else if (bus_mode == 2) c = c & ~(1 << idx);
          m_sel = c & 3; m_en = (c >> 4) & 15;
        end else if (bus_addr == 1 && bus_mode == 0) m_hi = int'(bus_wdata[7:0]);
        else if (bus_addr == 2 && bus_mode == 0) m_ptr[m_sel] = (m_hi << 16) | int'(bus_wdata);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    tests++;
    if (patch_req !== m_req) begin
      fails++; $display("FAIL R7 patch_req act=%0b exp=%0b", patch_req, m_req);
    end
    tests++;
    if (int'(patch_ch) != m_ch) begin
      fails++; $display("FAIL R8 patch_ch act=%0d exp=%0d", patch_ch, m_ch);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [1:0] md, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_mode = md; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_mode = 0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    bus_addr = a; #1;
    tests++;
    if (int'(bus_rdata) != exp) begin
      fails++; $display("FAIL %s reg%0d act=%h exp=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic fetch(input logic v, input logic [23:0] a);
    fetch_valid = v; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 0;
  endtask

  task automatic load(input int ch, input logic [7:0] hi, input logic [15:0] lo);
    wr(0, 0, 16'(ch));
    wr(1, 0, {8'h00, hi});
    wr(2, 0, lo);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R1");
        tests++;
        if (patch_req !== 1'b0) begin fails++; $display("FAIL R1 req act=%0b exp=0", patch_req); end
        // R6 zero pointers but disabled: fetch 0 gives nothing
        fetch(1, 24'h0); fetch(0, 24'h0);
        // R2 full write, reserved bits zero
        wr(0, 0, 16'hFFFF); rd(0, 'hF3, "R2");
        // R3 bit ops
        wr(0, 2, 16'h0007); rd(0, 'h73, "R3");
        wr(0, 1, 16'h0002); rd(0, 'h73, "R3");
        wr(0, 2, 16'h0000); rd(0, 'h72, "R3");
        wr(0, 1, 16'h0007); rd(0, 'hF2, "R3");
        wr(0, 3, 16'h0000); rd(0, 'hF2, "R3");
        wr(0, 0, 16'h0000);
        // R4 per-channel loads
        load(0, 8'h12, 16'h3456);
        load(1, 8'hA0, 16'h0100);
        load(2, 8'h7F, 16'hFFFE);
        load(3, 8'hA0, 16'h0100);
        for (int c = 0; c < 4; c++) begin
          wr(0, 0, 16'(c));
          rd(2, (c == 0) ? 'h3456 : (c == 2) ? 'hFFFE : 'h0100, "R4");
          rd(3, (c == 0) ? 'h12 : (c == 2) ? 'h7F : 'hA0, "R4");
        end
        // R5 staging only
        wr(1, 0, 16'h00C3); rd(1, 'hC3, "R5"); rd(3, 'hA0, "R5");
        wr(3, 0, 16'h5555); rd(3, 'hA0, "R5");
        wr(2, 1, 16'h0001); rd(2, 'h0100, "R3");
        // enable all, R7 match and back-to-back
        wr(0, 0, 16'h00F0);
        fetch(1, 24'h7FFFFE); fetch(1, 24'h123456); fetch(1, 24'h7FFFFE);
        fetch(0, 24'h7FFFFE);
        // R8 duplicates on 1 and 3
        fetch(1, 24'hA00100);
        wr(0, 2, 16'h0005); fetch(1, 24'hA00100);
        // R6 disable ch2
        wr(0, 2, 16'h0006); fetch(1, 24'h7FFFFE); fetch(1, 24'h7FFFFF);
        // R9 invalid fetch, and fetch in same cycle as enable write
        fetch(0, 24'h123456);
        fetch_valid = 1; fetch_addr = 24'h7FFFFE;
        wr(0, 1, 16'h0006);
        fetch_valid = 0;
        fetch(1, 24'h7FFFFE);
        fetch(0, 0); fetch(0, 0);
        disable fork;
      end
      begin
        repeat (5000) @(negedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule